// File: doc/BRIEF.md
# Line-Relative Clamp Pulse Generator

This block produces one clamp strobe per video line, timed in pixel clocks from the trailing edge of horizontal sync. After that edge it waits a programmable number of pixel clocks, the placement. It then raises the clamp for a second programmable number of pixel clocks, the duration. A sync polarity bit sets which input level counts as active sync, so the trailing edge can be either a falling or a rising transition of the input pin.

A select bit can bypass the internal timing and pass an externally supplied clamp signal to the output instead. A second bit inverts that external signal before it is used. Placement and duration are captured at each trailing edge. Software can therefore rewrite them at any point in a line without disturbing the pulse already in progress.

Top module: `clamp_pulse_gen`

## Requirements
- R1: After reset, with the internal source selected and sync held inactive, `clamp_out` is low.
- R2: If the polarity-corrected sync is first sampled inactive at clock edge E0 and placement P is nonzero, `clamp_out` stays low through the cycle after edge E0+P and goes high after edge E0+P+1.
- R3: With duration D greater than zero, the internal pulse stays high for exactly D cycles, which are the cycles after edges E0+P+1 through E0+P+D, and is then low.
- R4: With placement 0, the pulse starts in the cycle after edge E0+1, immediately after the edge is detected.
- R5: A duration of 0 produces no pulse for that line.
- R6: A new trailing edge during a waiting or active window restarts the placement count from that edge, ending any pulse in progress.
- R7: Placement and duration are captured at the trailing edge. Changes made during a line affect only the next line.
- R8: With `hsync_neg`=0, sync is active high and the trailing edge is a falling edge of `hsync_in`. With `hsync_neg`=1, sync is active low and the trailing edge is a rising edge of `hsync_in`.
- R9: With `use_ext`=1, `clamp_out` follows the external clamp input combinationally, and the internal window has no effect on the output.
- R10: With `ext_inv`=1, the external clamp input is inverted before it reaches `clamp_out`. With `ext_inv`=0, it passes unchanged.
- R11: With `use_ext`=0, the output is the internally timed pulse, whatever the external input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync input |
| hsync_neg | input | 1 | 1 = sync is active low |
| ext_clamp_in | input | 1 | External clamp input |
| ext_inv | input | 1 | 1 = invert the external clamp input |
| use_ext | input | 1 | 1 = select the external clamp, 0 = internal timing |
| place_cfg | input | PLACE_W | Pixel clocks from the trailing edge to the clamp start |
| dur_cfg | input | DUR_W | Clamp length in pixel clocks |
| clamp_out | output | 1 | Clamp strobe |

## Verification
The timing path is tried with several placement and duration pairs: zero placement, unit duration, zero duration, and longer values. Each line is checked cycle by cycle, so an off-by-one at either end of the window shows up, as does a suppressed line that still pulses. Extra tests separate the following behaviours:
- a restart from a second edge versus a window that finishes on its own;
- values captured at the edge versus values used live from the pins;
- falling versus rising trailing edges under the two sync polarities;
- a direct versus an inverted external source, including an internal window that must not leak onto the output.

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
  parameter int PLACE_W = 8,
  parameter int DUR_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync_in,
  input  logic               hsync_neg,
  input  logic               ext_clamp_in,
  input  logic               ext_inv,
  input  logic               use_ext,
  input  logic [PLACE_W-1:0] place_cfg,
  input  logic [DUR_W-1:0]   dur_cfg,
  output logic               clamp_out
);
  localparam int CNT_W = (PLACE_W > DUR_W) ? PLACE_W : DUR_W;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACT} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic [DUR_W-1:0] dur_hold;
  logic             hs_r, hs_rr;
  logic             trail, cnt_last, in_wait, clamp_int;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_r  <= 1'b0;
      hs_rr <= 1'b0;
    end else begin
      hs_r  <= hsync_in ^ hsync_neg;
      hs_rr <= hs_r;
    end

  assign trail     = hs_rr & ~hs_r;
  assign cnt_last  = (cnt == CNT_W'(1));
  assign in_wait   = (state == ST_WAIT);
  assign clamp_int = (state == ST_ACT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      dur_hold <= '0;
    end else if (trail) begin
      dur_hold <= dur_cfg;
      if (dur_cfg == '0) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (place_cfg == '0) begin
        state <= ST_ACT;
        cnt   <= CNT_W'(dur_cfg);
      end else begin
        state <= ST_WAIT;
        cnt   <= CNT_W'(place_cfg);
      end
    end else begin
      case (state)
        ST_WAIT:
          if (cnt_last) begin
            state <= ST_ACT;
            cnt   <= CNT_W'(dur_hold);
          end else cnt <= cnt - 1'b1;
        ST_ACT:
          if (cnt_last) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else cnt <= cnt - 1'b1;
        default: cnt <= '0;
      endcase
    end

  assign clamp_out = use_ext ? (ext_clamp_in ^ ext_inv) : clamp_int;
endmodule

module clamp_pulse_gen_chk #(
  parameter int PLACE_W = 8,
  parameter int DUR_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trail,
  input logic               clamp_int,
  input logic               in_wait,
  input logic               cnt_last,
  input logic [PLACE_W-1:0] place_cfg,
  input logic [DUR_W-1:0]   dur_cfg
);
  // R4
  zero_place_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail && dur_cfg != '0 && place_cfg == '0 |=> clamp_int);
  // R5
  zero_dur_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail && dur_cfg == '0 |=> !clamp_int);
  // R6
  restart_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail && place_cfg != '0 |=> !clamp_int);
  // R2
  start_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_int) |-> $past(in_wait || trail));
  // R3
  hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_int && !cnt_last && !trail |=> clamp_int);
  // R3
  end_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_int && cnt_last && !trail |=> !clamp_int);
endmodule

bind clamp_pulse_gen clamp_pulse_gen_chk #(.PLACE_W(PLACE_W), .DUR_W(DUR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trail(trail), .clamp_int(clamp_int),
  .in_wait(in_wait), .cnt_last(cnt_last), .place_cfg(place_cfg), .dur_cfg(dur_cfg)
);

// File: tb/clamp_pulse_gen_tb.sv
`timescale 1ns/1ps
module clamp_pulse_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hsync_in = 1'b0, hsync_neg = 1'b0, ext_clamp_in = 1'b0, ext_inv = 1'b0, use_ext = 1'b0;
  logic [7:0] place_cfg = 8'd0, dur_cfg = 8'd0;
  logic clamp_out;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  clamp_pulse_gen dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .hsync_neg(hsync_neg),
    .ext_clamp_in(ext_clamp_in), .ext_inv(ext_inv), .use_ext(use_ext),
    .place_cfg(place_cfg), .dur_cfg(dur_cfg), .clamp_out(clamp_out)
  );

  // {placement, duration, sync active low}
  localparam logic [16:0] VEC [8] = '{
    {8'd0, 8'd1, 1'b0}, {8'd0, 8'd3, 1'b0}, {8'd2, 8'd4, 1'b0}, {8'd5, 8'd1, 1'b0},
    {8'd3, 8'd0, 1'b0}, {8'd1, 8'd2, 1'b1}, {8'd7, 8'd6, 1'b0}, {8'd0, 8'd0, 1'b1}
  };

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: clamp_out=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic start_line(input int p, input int d, input logic neg);
    place_cfg = 8'(p);
    dur_cfg   = 8'(d);
    hsync_neg = neg;
    hsync_in  = ~neg;
    repeat (3) @(negedge clk);
    hsync_in  = neg;
  endtask

  task automatic run_line(input int p, input int d, input logic neg, input logic exp_on, input string req);
    start_line(p, d, neg);
    for (int n = 1; n <= p + d + 3; n++) begin
      @(negedge clk);
      check(clamp_out, exp_on && (n >= p + 2) && (n <= p + d + 1), req);
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(clamp_out, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(clamp_out, 1'b0, "R1 after reset");

    // R2 R3 R4 R5 R8: table of placement/duration/polarity lines
    for (int i = 0; i < 8; i++)
      run_line(int'(VEC[i][16:9]), int'(VEC[i][8:1]), VEC[i][0], 1'b1, "R2_R3_R4_R5_R8 table");

    // R6: second trailing edge inside the active window
    start_line(4, 5, 1'b0);
    for (int m = 1; m <= 7; m++) @(negedge clk);
    hsync_in = 1'b1;
    repeat (2) @(negedge clk);
    hsync_in = 1'b0;
    for (int n = 1; n <= 11; n++) begin
      @(negedge clk);
      if (n >= 2) check(clamp_out, (n >= 6) && (n <= 10), "R6 restart");
    end

    // R7: mid-line config change is held off until the next edge
    start_line(2, 3, 1'b0);
    for (int n = 1; n <= 7; n++) begin
      @(negedge clk);
      check(clamp_out, (n >= 4) && (n <= 6), "R7 old values kept");
      if (n == 2) begin place_cfg = 8'd0; dur_cfg = 8'd8; end
    end
    hsync_in = 1'b1;
    repeat (3) @(negedge clk);
    hsync_in = 1'b0;
    for (int n = 1; n <= 11; n++) begin
      @(negedge clk);
      check(clamp_out, (n >= 2) && (n <= 9), "R7 new values next line");
    end

    // R11: external input ignored when internal source selected
    ext_clamp_in = 1'b1; ext_inv = 1'b1;
    run_line(1, 2, 1'b0, 1'b1, "R11 internal ignores ext");

    // R9: external source selected, internal window must not show
    use_ext = 1'b1; ext_inv = 1'b0; ext_clamp_in = 1'b0;
    run_line(0, 4, 1'b0, 1'b0, "R9 internal window hidden");
    ext_clamp_in = 1'b1; #1;
    check(clamp_out, 1'b1, "R9 ext high");
    ext_clamp_in = 1'b0; #1;
    check(clamp_out, 1'b0, "R9 ext low");

    // R10: inversion of the external input
    ext_inv = 1'b1; #1;
    check(clamp_out, 1'b1, "R10 inverted low");
    ext_clamp_in = 1'b1; #1;
    check(clamp_out, 1'b0, "R10 inverted high");

    // R1: reset mid-window clears the pulse
    use_ext = 1'b0;
    start_line(0, 6, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b0; #1;
    check(clamp_out, 1'b0, "R1 reset mid-window");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule